// File: doc/BRIEF.md
# ADC Clock and Trigger Controller

This block sits beside an analog-to-digital converter and does two jobs. It divides the system clock into a conversion clock, emitted as a one-cycle enable strobe whose period is picked by a 3-bit divider code. It also decides when a conversion begins, and marks that moment with a one-cycle start pulse.

A conversion can begin in two ways. Software can ask for one directly. Or, when automatic triggering is on, a rising edge on one of eight trigger sources starts one. The sources are seven event flags from other peripherals and the converter's own conversion-complete flag. The complete flag is the free-running source, so each finished conversion launches the next. The edge is detected after the source multiplexer, so changing the source code alone can produce an edge. Moving the code to free-running never produces one.

The converter is modelled as a busy/done handshake. A start pulse makes the block busy. A rising edge on the conversion-complete flag makes it idle again.

Top module: `adc_clk_trig_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `conv_clk_en_o` and `start_o` are 0.
- R2: While `adc_en_i` is held high, `conv_clk_en_o` is high for exactly one cycle out of every F cycles. F is 2 for divider codes 000 and 001, and 2^k for code k from 010 to 111 (4, 8, 16, 32, 64, 128). Counting the cycles in which the enable is high, the first pulse falls in cycle F.
- R3: While `adc_en_i` is low, `conv_clk_en_o` stays 0 and the divider count returns to zero, so the pulse phase restarts as in R2 on the next enable.
- R4: Trigger code 000 selects `conv_done_i` as the source. A code k from 001 to 111 selects `evt_flags_i[k-1]`. Flags that are not selected have no effect.
- R5: When auto-trigger is on, the ADC is enabled and the block is idle, a low-to-high change of the selected source gives exactly one `start_o` pulse in the next cycle. A source that stays high starts nothing further.
- R6: When `auto_trig_en_i` is low, no source or select change starts a conversion.
- R7: Changing the trigger code from a source that is low to a source that is high counts as a rising edge, and a conversion starts (R5 timing).
- R8: Changing the trigger code to 000 never counts as an edge, even when `conv_done_i` is already high.
- R9: While `adc_en_i` is low, trigger edges and manual requests are ignored, and the busy state is cleared.
- R10: From a start pulse until the next rising edge of `conv_done_i`, trigger edges and manual requests are ignored and are not remembered.
- R11: In free-running mode (code 000, auto-trigger on), the rising edge of `conv_done_i` that ends a conversion also starts the next one, with `start_o` high in the following cycle.
- R12: A high `start_req_i` while the ADC is enabled and idle gives one `start_o` pulse in the next cycle. A manual request and a trigger edge in the same cycle give a single pulse.
- R13: `start_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_en_i | input | 1 | ADC enable |
| div_sel_i | input | 3 | Conversion clock divider code |
| auto_trig_en_i | input | 1 | Automatic trigger enable |
| trig_sel_i | input | 3 | Trigger source code |
| evt_flags_i | input | 7 | Peripheral event flags, bit k-1 for source code k |
| start_req_i | input | 1 | Manual start request |
| conv_done_i | input | 1 | Conversion-complete flag |
| conv_clk_en_o | output | 1 | Conversion clock enable strobe |
| start_o | output | 1 | Start-of-conversion pulse |

## Verification
Two pairs of functions can land in the same cycle. The first is a manual start request and a trigger edge. The bench raises the selected event flag and `start_req_i` on the same falling edge and expects exactly one start pulse one cycle later; a second pulse would be reported as unexpected. The second pair arises in free-running mode, where the done edge both ends the current conversion and triggers the next one. Here the bench expects the new pulse in the cycle right after the done edge, which shows that the busy release and the trigger are handled in the same cycle.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int unsigned DIV_SEL_W = 3;
  localparam int unsigned N_EVT     = 7;

  typedef enum logic [2:0] {
    TRIG_FREE    = 3'd0,
    TRIG_ACMP    = 3'd1,
    TRIG_EXT0    = 3'd2,
    TRIG_T0_CMP  = 3'd3,
    TRIG_T0_OVF  = 3'd4,
    TRIG_T1_CMPB = 3'd5,
    TRIG_T1_OVF  = 3'd6,
    TRIG_T1_CAP  = 3'd7
  } trig_src_e;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;
  logic [SEL_W-1:0] shamt;

  // codes 0 and 1 both divide by two
  always_comb begin
    shamt = (sel_i == '0) ? SEL_W'(1) : sel_i;
    lim   = CNT_W'((1 << shamt) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q >= lim);
endmodule

// File: rtl/adc_trig_src.sv
module adc_trig_src #(
  parameter int unsigned N_EVT = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             done_i,
  output logic             edge_o
);
  localparam int unsigned N_SRC = N_EVT + 1;

  logic [N_SRC-1:0] src_vec;
  logic             src, src_q;
  logic [SEL_W-1:0] sel_q;
  logic             to_free;

  assign src_vec = {evt_i, done_i};

  always_comb begin
    src = 1'b0;
    for (int k = 0; k < N_SRC; k++)
      if (sel_i == SEL_W'(k)) src = src_vec[k];
  end

  // moving onto free-running is never an edge
  assign to_free = (sel_i == '0) && (sel_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      sel_q <= '0;
    end else begin
      src_q <= src;
      sel_q <= sel_i;
    end
  end

  assign edge_o = auto_en_i && src && !src_q && !to_free;
endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adc_en_i,
  input  logic trig_i,
  input  logic req_i,
  input  logic done_i,
  output logic start_o
);
  logic busy_q, done_q, done_rise, idle, accept;

  assign done_rise = done_i && !done_q;
  // a done edge frees the slot in the same cycle (free-running restart)
  assign idle      = !busy_q || done_rise;
  assign accept    = adc_en_i && idle && (trig_i || req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      done_q  <= done_i;
      start_o <= accept;
      if (!adc_en_i)      busy_q <= 1'b0;
      else if (accept)    busy_q <= 1'b1;
      else if (done_rise) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_clk_trig_ctrl.sv
module adc_clk_trig_ctrl #(
  parameter int unsigned DIV_SEL_W = adc_ctl_pkg::DIV_SEL_W,
  parameter int unsigned N_EVT     = adc_ctl_pkg::N_EVT,
  localparam int unsigned TRIG_W   = $clog2(N_EVT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adc_en_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 auto_trig_en_i,
  input  logic [TRIG_W-1:0]    trig_sel_i,
  input  logic [N_EVT-1:0]     evt_flags_i,
  input  logic                 start_req_i,
  input  logic                 conv_done_i,
  output logic                 conv_clk_en_o,
  output logic                 start_o
);
  logic trig_edge;

  adc_prescaler #(.SEL_W(DIV_SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adc_en_i),
    .sel_i  (div_sel_i),
    .tick_o (conv_clk_en_o)
  );

  adc_trig_src #(.N_EVT(N_EVT), .SEL_W(TRIG_W)) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .auto_en_i (auto_trig_en_i),
    .sel_i     (trig_sel_i),
    .evt_i     (evt_flags_i),
    .done_i    (conv_done_i),
    .edge_o    (trig_edge)
  );

  adc_start_ctl u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adc_en_i (adc_en_i),
    .trig_i   (trig_edge),
    .req_i    (start_req_i),
    .done_i   (conv_done_i),
    .start_o  (start_o)
  );
endmodule

// File: rtl/adc_clk_trig_ctrl_chk.sv
module adc_clk_trig_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic adc_en_i,
  input logic auto_trig_en_i,
  input logic start_req_i,
  input logic conv_clk_en_o,
  input logic start_o
);
  assert_single_start_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_clk_strobe_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_clk_en_o |=> !conv_clk_en_o);

  assert_clk_off_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(adc_en_i) |-> !conv_clk_en_o);

  assert_no_start_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(adc_en_i) |-> !start_o);

  assert_manual_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !$past(auto_trig_en_i)) |-> $past(start_req_i));

  assert_start_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(start_req_i) || $past(auto_trig_en_i)));
endmodule

bind adc_clk_trig_ctrl adc_clk_trig_ctrl_chk u_chk (.*);

// File: tb/adc_clk_trig_ctrl_test.sv
module adc_clk_trig_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       adc_en = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       auto_en = 1'b0;
  logic [2:0] trig_sel = 3'd0;
  logic [6:0] evt = '0;
  logic       start_req = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_clk_en, start;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    ended = 1'b0;
  string cur_req = "R1";
  int    exp_cyc[$];
  string exp_req[$];

  adc_clk_trig_ctrl uut (
    .clk_i (clk), .rst_ni (rst_ni), .adc_en_i (adc_en), .div_sel_i (div_sel),
    .auto_trig_en_i (auto_en), .trig_sel_i (trig_sel), .evt_flags_i (evt),
    .start_req_i (start_req), .conv_done_i (conv_done),
    .conv_clk_en_o (conv_clk_en), .start_o (start)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_start(string r);
    exp_cyc.push_back(cyc + 1);
    exp_req.push_back(r);
  endtask

  task automatic drain(string r);
    tick(3);
    chk(r, exp_cyc.size(), 0);
    exp_cyc.delete();
    exp_req.delete();
  endtask

  task automatic done_pulse();
    conv_done = 1'b1; tick(1);
    conv_done = 1'b0; tick(1);
  endtask

  // monitor: pops expected start cycles and compares
  always @(negedge clk) begin
    if (rst_ni && !ended && start) begin
      if (exp_cyc.size() == 0) chk(cur_req, 1, 0);
      else begin
        int    c;
        string r;
        c = exp_cyc.pop_front();
        r = exp_req.pop_front();
        chk(r, cyc, c);
      end
    end
  end

  // R2, R3: strobe pattern after (re)enable
  task automatic clk_check(logic [2:0] s);
    int f, bad;
    f   = (s < 3'd2) ? 2 : (1 << s);
    bad = 0;
    adc_en = 1'b0; div_sel = s; tick(1);
    #1 chk("R3", int'(conv_clk_en), 0);
    @(negedge clk);
    adc_en = 1'b1;
    for (int i = 0; i < 3 * f + 1; i++) begin
      #1 if (conv_clk_en != ((i % f) == f - 1)) bad++;
      @(negedge clk);
    end
    chk("R2", bad, 0);
  endtask

  initial begin
    tick(2);
    chk("R1", int'(start), 0);
    chk("R1", int'(conv_clk_en), 0);
    rst_ni = 1'b1;
    tick(1);
    chk("R1", int'(start) + int'(conv_clk_en), 0);

    clk_check(3'd2);
    clk_check(3'd0);
    clk_check(3'd1);
    clk_check(3'd3);
    clk_check(3'd5);
    clk_check(3'd7);
    adc_en = 1'b0; tick(1);
    for (int i = 0; i < 5; i++) begin
      #1 chk("R3", int'(conv_clk_en), 0);
      @(negedge clk);
    end

    // R12 manual start, R13 single pulse, R10 busy
    adc_en = 1'b1; trig_sel = 3'd1; tick(1);
    cur_req = "R12";
    start_req = 1'b1; expect_start("R12"); tick(1);
    start_req = 1'b0; tick(1);
    #1 chk("R13", int'(start), 0);
    cur_req = "R10";
    start_req = 1'b1; tick(1); start_req = 1'b0;
    drain("R10");
    done_pulse();
    cur_req = "R12";
    start_req = 1'b1; expect_start("R12"); tick(1); start_req = 1'b0;
    drain("R12");
    done_pulse();

    // R6: auto-trigger off
    cur_req = "R6";
    evt[0] = 1'b1; tick(1); trig_sel = 3'd3; evt[2] = 1'b1; tick(1);
    drain("R6");
    evt = '0; trig_sel = 3'd1; tick(1);

    // R4, R5: every event code
    auto_en = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      trig_sel = 3'(k); tick(1);
      cur_req = "R5";
      evt[k-1] = 1'b1; expect_start("R4"); tick(1);
      drain("R5");
      done_pulse();
      cur_req = "R4";
      evt[k % 7] = 1'b1; conv_done = 1'b1; tick(1);
      drain("R4");
      conv_done = 1'b0; evt = '0; tick(1);
    end

    // R7: select change onto a high flag
    trig_sel = 3'd1; evt[2] = 1'b1; tick(1);
    cur_req = "R7";
    trig_sel = 3'd3; expect_start("R7"); tick(1);
    drain("R7");
    done_pulse();
    evt = '0; tick(1);

    // R8: switch to free-running with done already high
    cur_req = "R8";
    conv_done = 1'b1; tick(2);
    trig_sel = 3'd0; tick(1);
    drain("R8");
    conv_done = 1'b0; tick(2);

    // R11: free-running restart on each done edge
    cur_req = "R11";
    start_req = 1'b1; expect_start("R11"); tick(1); start_req = 1'b0; tick(2);
    for (int n = 0; n < 3; n++) begin
      conv_done = 1'b1; expect_start("R11"); tick(1);
      conv_done = 1'b0; tick(3);
    end
    chk("R11", exp_cyc.size(), 0);
    auto_en = 1'b0; done_pulse(); auto_en = 1'b1;
    drain("R11");

    // R10: trigger edge while busy is dropped
    trig_sel = 3'd1; tick(1);
    cur_req = "R10";
    evt[0] = 1'b1; expect_start("R10"); tick(1);
    evt[0] = 1'b0; tick(1);
    evt[0] = 1'b1; tick(1);
    drain("R10");
    done_pulse();
    drain("R10");
    evt[0] = 1'b0; tick(1);

    // R9: disabled ADC ignores everything
    cur_req = "R9";
    adc_en = 1'b0; tick(1);
    evt[0] = 1'b1; tick(1);
    start_req = 1'b1; tick(1); start_req = 1'b0;
    drain("R9");
    evt[0] = 1'b0; adc_en = 1'b1; tick(1);

    // R12: manual request and trigger edge together
    cur_req = "R12";
    evt[0] = 1'b1; start_req = 1'b1; expect_start("R12"); tick(1);
    start_req = 1'b0;
    drain("R12");
    done_pulse();
    evt[0] = 1'b0; tick(2);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule